// File: doc/BRIEF.md
# Multidrop Serial Receiver-Transmitter with Node Address Filter

This block is an asynchronous serial port that sends and receives 11-bit frames: a low start bit, eight payload bits sent least significant first, a ninth bit, and a high stop bit. The transmitter and receiver have separate shift registers, so both directions can be active at once. Bit timing comes from an external enable, `tick16`, that pulses sixteen times per bit period. The baud generator that makes this enable is outside the block.

The receiver is built for a shared multidrop line. In address-filter mode, frames whose ninth bit is clear are dropped. A frame whose ninth bit is set is kept only when its byte matches this node's masked address or the broadcast pattern. The node address and the address mask are inputs.

The receive-done, transmit-done and framing-error flags are set by hardware and stay set until a clear input drops them. The framing-error flag is not read on a port of its own. It shares one output with a mode bit supplied from outside, and a select input picks which of the two is shown.

Top module: `mpuart_node`

## Requirements
- R1: With `sm2`=0, a received frame loads its payload into `rx_data` and its ninth bit into `rx_bit9`. `ri` rises partway through the stop bit. It is still low a quarter of the way into the stop bit and high before the stop bit ends.
- R2: On each tick the receiver looks for a low line while idle. It decides each bit by a 2-of-3 vote over samples 7, 8 and 9 of the 16 per bit. A start bit that votes high is treated as a false start: the receiver returns to idle and nothing is loaded. A following valid frame is still received.
- R3: `fe` is set when the stop bit votes low. `fe_or_mode` shows the framing-error flag while `fe_view`=1 and shows `mode_bit` while `fe_view`=0.
- R4: With `sm2`=1, a frame whose ninth bit is 0 does not set `ri` and leaves `rx_data` unchanged.
- R5: With `sm2`=1, a frame with ninth bit 1 is accepted when (byte AND `addr_mask`) equals (`node_addr` AND `addr_mask`).
- R6: With `sm2`=1, a frame with ninth bit 1 is also accepted when the byte has a 1 in every bit position where (`node_addr` OR `addr_mask`) is 1.
- R7: With `sm2`=1, a frame with ninth bit 1 that matches neither rule leaves `ri` low and `rx_data` unchanged.
- R8: A `tx_load` pulse while idle sends a frame on `txd` in this order: start 0, `tx_data` least significant bit first, `tx_bit9`, stop 1. Each bit lasts 16 ticks. `ti` is low during the ninth bit and rises at the start of the stop bit. `txd` is high whenever `tx_busy` is low.
- R9: `ri`, `ti` and the framing-error flag stay set until their clear input (`clr_ri`, `clr_ti`, `clr_fe`) is pulsed. A set and a clear in the same cycle leave the flag set.
- R10: A `tx_load` pulse while `tx_busy`=1 is ignored. The frame in progress finishes unchanged and no second frame follows.
- R11: A frame can be received while a frame is being transmitted, and both are correct.
- R12: After reset, `txd`=1, `tx_busy`=0, and `ri`, `ti` and the framing-error flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversample enable, 16 per bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_load | input | 1 | Start a transmit frame |
| tx_data | input | DATA_W | Transmit payload |
| tx_bit9 | input | 1 | Transmit ninth bit |
| tx_busy | output | 1 | Transmitter active |
| rx_data | output | DATA_W | Last accepted payload |
| rx_bit9 | output | 1 | Last accepted ninth bit |
| sm2 | input | 1 | Address-filter mode enable |
| node_addr | input | DATA_W | This node's address |
| addr_mask | input | DATA_W | Address mask |
| fe_view | input | 1 | 1 selects the framing-error flag onto fe_or_mode |
| mode_bit | input | 1 | Mode bit shown while fe_view=0 |
| fe_or_mode | output | 1 | Framing-error flag or mode bit |
| ri | output | 1 | Receive-done flag |
| ti | output | 1 | Transmit-done flag |
| clr_ri | input | 1 | Clear ri |
| clr_ti | input | 1 | Clear ti |
| clr_fe | input | 1 | Clear framing-error flag |

## Verification
Some properties are checked by assertions on every cycle. The transmit line stays high when the transmitter is idle. `ti` rises only while the stop level is on the line. The three flags fall only after their clear input. In filter mode, `ri` never rises for a frame whose ninth bit is 0.

Other behaviour can only be shown by the directed scenarios. These cover bit order and timing on the line, the majority-vote rejection of a false start, the masked-address and broadcast acceptance rules, a rejected address that leaves the data register untouched, a load ignored while busy, the shared flag output, and receiving while transmitting.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/mpuart_flags.sv
module mpuart_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q_o[g] <= 1'b0;
         else if (set_i[g]) q_o[g] <= 1'b1;
         else if (clr_i[g]) q_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/mpuart_addr_match.sv
module mpuart_addr_match #(
   parameter int DATA_W   = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic [DATA_W-1:0] addr_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              hit_o
);
   logic hit_given;
   assign hit_given = ((byte_i & mask_i) == (addr_i & mask_i));

   if (BCAST_EN) begin : g_bcast
      logic [DATA_W-1:0] bcast;
      assign bcast = addr_i | mask_i;
      assign hit_o = hit_given | ((byte_i & bcast) == bcast);
   end else begin : g_nobcast
      assign hit_o = hit_given;
   end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
   import mpuart_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   output logic              done_o,
   output logic              bad_stop_o,
   output logic [DATA_W-1:0] data_o,
   output logic              bit9_o
);
   localparam int NBITS = DATA_W + 1;
   localparam int CNT_W = $clog2(OSR);
   localparam int BIT_W = $clog2(NBITS + 1);
   localparam logic [CNT_W-1:0] S_LO  = CNT_W'(OSR / 2 - 1);
   localparam logic [CNT_W-1:0] S_MID = CNT_W'(OSR / 2);
   localparam logic [CNT_W-1:0] S_HI  = CNT_W'(OSR / 2 + 1);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(OSR - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rx_s;
   rx_state_e              state;
   logic [CNT_W-1:0]       tcnt;
   logic [BIT_W-1:0]       bidx;
   logic [NBITS-1:0]       shreg;
   logic [1:0]             vote;
   logic                   bit_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
   end
   assign rx_s  = sync_q[SYNC_STAGES-1];
   assign bit_v = vote3(vote[0], vote[1], rx_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         tcnt       <= '0;
         bidx       <= '0;
         shreg      <= '0;
         vote       <= '0;
         done_o     <= 1'b0;
         bad_stop_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            if (state == RX_IDLE) begin
               if (!rx_s) begin
                  state <= RX_START;
                  tcnt  <= '0;
               end
            end else begin
               tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
               if (tcnt == S_LO)  vote[0] <= rx_s;
               if (tcnt == S_MID) vote[1] <= rx_s;
               if (tcnt == S_HI) begin
                  case (state)
                     RX_START: if (bit_v) state <= RX_IDLE;
                     RX_BITS: begin
                        shreg <= {bit_v, shreg[NBITS-1:1]};
                        bidx  <= bidx + 1'b1;
                     end
                     RX_STOP: begin
                        done_o     <= 1'b1;
                        bad_stop_o <= ~bit_v;
                        state      <= RX_IDLE;
                     end
                     default: ;
                  endcase
               end
               if (tcnt == LAST) begin
                  if (state == RX_START) begin
                     state <= RX_BITS;
                     bidx  <= '0;
                  end else if (state == RX_BITS && bidx == BIT_W'(NBITS)) begin
                     state <= RX_STOP;
                  end
               end
            end
         end
      end
   end

   assign data_o = shreg[DATA_W-1:0];
   assign bit9_o = shreg[NBITS-1];
endmodule

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              bit9_i,
   output logic              txd_o,
   output logic              busy_o,
   output logic              stop_begin_o
);
   localparam int FW    = DATA_W + 3;
   localparam int BW    = $clog2(FW);
   localparam int CNT_W = $clog2(OSR);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

   logic [FW-1:0]    shreg;
   logic [CNT_W-1:0] tcnt;
   logic [BW-1:0]    bidx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg        <= '1;
         tcnt         <= '0;
         bidx         <= '0;
         busy_o       <= 1'b0;
         stop_begin_o <= 1'b0;
      end else begin
         stop_begin_o <= 1'b0;
         if (!busy_o) begin
            if (load_i) begin
               shreg  <= {1'b1, bit9_i, data_i, 1'b0};
               busy_o <= 1'b1;
               tcnt   <= '0;
               bidx   <= '0;
            end
         end else if (tick_i) begin
            tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
            if (tcnt == LAST) begin
               if (bidx == BW'(FW - 1)) begin
                  busy_o <= 1'b0;
               end else begin
                  shreg <= {1'b1, shreg[FW-1:1]};
                  bidx  <= bidx + 1'b1;
                  if (bidx == BW'(FW - 2)) stop_begin_o <= 1'b1;
               end
            end
         end
      end
   end

   assign txd_o = busy_o ? shreg[0] : 1'b1;
endmodule

// File: rtl/mpuart_node.sv
module mpuart_node #(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit BCAST_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              rxd,
   output logic              txd,
   input  logic              tx_load,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_bit9,
   output logic              tx_busy,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_bit9,
   input  logic              sm2,
   input  logic [DATA_W-1:0] node_addr,
   input  logic [DATA_W-1:0] addr_mask,
   input  logic              fe_view,
   input  logic              mode_bit,
   output logic              fe_or_mode,
   output logic              ri,
   output logic              ti,
   input  logic              clr_ri,
   input  logic              clr_ti,
   input  logic              clr_fe
);
   if (OSR < 8)         begin : g_chk_osr  $error("OSR must be at least 8"); end
   if (SYNC_STAGES < 2) begin : g_chk_sync $error("SYNC_STAGES must be at least 2"); end
   if (DATA_W < 1)      begin : g_chk_dw   $error("DATA_W must be positive"); end

   logic              fr_done, fr_bad;
   logic [DATA_W-1:0] fr_data;
   logic              fr_b9;
   logic              addr_hit;
   logic              accept;
   logic              ti_set;
   logic              fe_flag;
   logic [2:0]        flag_q;

   mpuart_rx #(.DATA_W(DATA_W), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) rx_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick16), .rxd_i(rxd),
      .done_o(fr_done), .bad_stop_o(fr_bad), .data_o(fr_data), .bit9_o(fr_b9)
   );

   mpuart_addr_match #(.DATA_W(DATA_W), .BCAST_EN(BCAST_EN)) match_i (
      .byte_i(fr_data), .addr_i(node_addr), .mask_i(addr_mask), .hit_o(addr_hit)
   );

   mpuart_tx #(.DATA_W(DATA_W), .OSR(OSR)) tx_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick16), .load_i(tx_load),
      .data_i(tx_data), .bit9_i(tx_bit9), .txd_o(txd), .busy_o(tx_busy),
      .stop_begin_o(ti_set)
   );

   assign accept = fr_done & (~sm2 | (fr_b9 & addr_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_bit9 <= 1'b0;
      end else if (accept) begin
         rx_data <= fr_data;
         rx_bit9 <= fr_b9;
      end
   end

   mpuart_flags #(.N(3)) flags_i (
      .clk(clk), .rst_n(rst_n),
      .set_i({fr_done & fr_bad, ti_set, accept}),
      .clr_i({clr_fe, clr_ti, clr_ri}),
      .q_o(flag_q)
   );

   assign ri         = flag_q[0];
   assign ti         = flag_q[1];
   assign fe_flag    = flag_q[2];
   assign fe_or_mode = fe_view ? fe_flag : mode_bit;
endmodule

// File: rtl/mpuart_chk.sv
module mpuart_chk (
   input logic clk,
   input logic rst_n,
   input logic sm2,
   input logic tx_busy,
   input logic txd,
   input logic ti,
   input logic ri,
   input logic rx_bit9,
   input logic clr_ri,
   input logic clr_ti,
   input logic clr_fe,
   input logic fe_q
);
   a_r8_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);
   a_r8_ti_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ti) |-> (tx_busy && txd));
   a_r9_ri_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ri && !clr_ri) |=> ri);
   a_r9_ti_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ti && !clr_ti) |=> ti);
   a_r9_ri_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ri) |-> $past(clr_ri));
   a_r3_fe_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fe_q) |-> $past(clr_fe));
   a_r4_filter_bit9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ri) && $past(sm2)) |-> rx_bit9);
endmodule

bind mpuart_node mpuart_chk chk_i (
   .clk(clk), .rst_n(rst_n), .sm2(sm2), .tx_busy(tx_busy), .txd(txd),
   .ti(ti), .ri(ri), .rx_bit9(rx_bit9), .clr_ri(clr_ri), .clr_ti(clr_ti),
   .clr_fe(clr_fe), .fe_q(fe_flag)
);

// File: tb/mpuart_node_tb.sv
module mpuart_node_tb_top;
   localparam int BITCLK = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic       txd;
   logic       tx_load = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_bit9 = 1'b0;
   logic       tx_busy;
   logic [7:0] rx_data;
   logic       rx_bit9;
   logic       sm2 = 1'b0;
   logic [7:0] node_addr = '0;
   logic [7:0] addr_mask = '0;
   logic       fe_view = 1'b1;
   logic       mode_bit = 1'b0;
   logic       fe_or_mode;
   logic       ri, ti;
   logic       clr_ri = 1'b0, clr_ti = 1'b0, clr_fe = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   logic ri_quarter_stop;

   mpuart_node dut_i (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .txd(txd),
      .tx_load(tx_load), .tx_data(tx_data), .tx_bit9(tx_bit9), .tx_busy(tx_busy),
      .rx_data(rx_data), .rx_bit9(rx_bit9), .sm2(sm2), .node_addr(node_addr),
      .addr_mask(addr_mask), .fe_view(fe_view), .mode_bit(mode_bit),
      .fe_or_mode(fe_or_mode), .ri(ri), .ti(ti), .clr_ri(clr_ri),
      .clr_ti(clr_ti), .clr_fe(clr_fe)
   );

   always #4 clk = ~clk;

   initial begin
      int tc = 0;
      forever begin
         @(negedge clk);
         tc++;
         tick16 = (tc % 4 == 0);
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clears(input logic r, input logic t, input logic f);
      @(negedge clk);
      clr_ri = r; clr_ti = t; clr_fe = f;
      @(negedge clk);
      clr_ri = 1'b0; clr_ti = 1'b0; clr_fe = 1'b0;
      wait_clk(2);
   endtask

   task automatic send_frame(input logic [7:0] d, input logic b9, input logic stopv);
      logic [9:0] bits;
      bits = {b9, d, 1'b0};
      for (int i = 0; i < 10; i++) begin
         rxd = bits[i];
         wait_clk(BITCLK);
      end
      rxd = stopv;
      wait_clk(16);
      ri_quarter_stop = ri;
      wait_clk(BITCLK - 16);
      rxd = 1'b1;
      wait_clk(stopv ? BITCLK : 3 * BITCLK);
   endtask

   task automatic tx_frame(input logic [7:0] d, input logic b9, input logic reload, input string req);
      logic [10:0] exp_bits;
      exp_bits = {1'b1, b9, d, 1'b0};
      @(negedge clk);
      tx_data = d; tx_bit9 = b9; tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
      wait_clk(BITCLK / 2 - 1);
      for (int i = 0; i < 11; i++) begin
         chk(req, {15'd0, txd}, {15'd0, exp_bits[i]});
         chk(req, {15'd0, tx_busy}, 16'd1);
         if (i == 9)  chk("R8 ti low in bit9", {15'd0, ti}, 16'd0);
         if (i == 10) chk("R8 ti in stop", {15'd0, ti}, 16'd1);
         if (reload && i == 2) begin
            tx_data = ~d; tx_bit9 = ~b9; tx_load = 1'b1;
            @(negedge clk);
            tx_load = 1'b0;
            wait_clk(BITCLK - 1);
         end else begin
            wait_clk(BITCLK);
         end
      end
      wait_clk(BITCLK);
      chk(req, {15'd0, tx_busy}, 16'd0);
      chk(req, {15'd0, txd}, 16'd1);
   endtask

   task automatic t_reset;
      chk("R12 txd", {15'd0, txd}, 16'd1);
      chk("R12 tx_busy", {15'd0, tx_busy}, 16'd0);
      chk("R12 ri", {15'd0, ri}, 16'd0);
      chk("R12 ti", {15'd0, ti}, 16'd0);
      chk("R12 fe", {15'd0, fe_or_mode}, 16'd0);
   endtask

   task automatic t_basic_rx;
      sm2 = 1'b0;
      send_frame(8'hA5, 1'b1, 1'b1);
      chk("R1 ri quarter stop", {15'd0, ri_quarter_stop}, 16'd0);
      chk("R1 ri", {15'd0, ri}, 16'd1);
      chk("R1 data", {8'd0, rx_data}, 16'h00A5);
      chk("R1 bit9", {15'd0, rx_bit9}, 16'd1);
      chk("R3 no fe", {15'd0, fe_or_mode}, 16'd0);
      wait_clk(300);
      chk("R9 ri holds", {15'd0, ri}, 16'd1);
      pulse_clears(1'b1, 1'b0, 1'b0);
      chk("R9 ri cleared", {15'd0, ri}, 16'd0);
      send_frame(8'h3E, 1'b0, 1'b1);
      chk("R1 data2", {8'd0, rx_data}, 16'h003E);
      chk("R1 bit9 2", {15'd0, rx_bit9}, 16'd0);
      pulse_clears(1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_glitch;
      @(negedge clk);
      rxd = 1'b0;
      wait_clk(12);
      rxd = 1'b1;
      wait_clk(12 * BITCLK);
      chk("R2 false start no ri", {15'd0, ri}, 16'd0);
      chk("R2 false start data", {8'd0, rx_data}, 16'h003E);
      send_frame(8'h3C, 1'b1, 1'b1);
      chk("R2 recovers ri", {15'd0, ri}, 16'd1);
      chk("R2 recovers data", {8'd0, rx_data}, 16'h003C);
      pulse_clears(1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_framing;
      send_frame(8'h55, 1'b0, 1'b0);
      fe_view = 1'b1;
      wait_clk(1);
      chk("R3 fe set", {15'd0, fe_or_mode}, 16'd1);
      fe_view = 1'b0; mode_bit = 1'b0;
      wait_clk(1);
      chk("R3 mode view 0", {15'd0, fe_or_mode}, 16'd0);
      mode_bit = 1'b1;
      wait_clk(1);
      chk("R3 mode view 1", {15'd0, fe_or_mode}, 16'd1);
      fe_view = 1'b1;
      wait_clk(200);
      chk("R9 fe holds", {15'd0, fe_or_mode}, 16'd1);
      pulse_clears(1'b1, 1'b0, 1'b1);
      chk("R9 fe cleared", {15'd0, fe_or_mode}, 16'd0);
   endtask

   task automatic t_filter;
      sm2 = 1'b1; node_addr = 8'h5A; addr_mask = 8'hFF;
      send_frame(8'h5A, 1'b0, 1'b1);
      chk("R4 data frame dropped ri", {15'd0, ri}, 16'd0);
      chk("R4 data unchanged", {8'd0, rx_data}, 16'h0055);
      send_frame(8'h5A, 1'b1, 1'b1);
      chk("R5 exact match ri", {15'd0, ri}, 16'd1);
      chk("R5 exact match data", {8'd0, rx_data}, 16'h005A);
      pulse_clears(1'b1, 1'b0, 1'b0);
      addr_mask = 8'hF0;
      send_frame(8'h53, 1'b1, 1'b1);
      chk("R5 masked match ri", {15'd0, ri}, 16'd1);
      chk("R5 masked match data", {8'd0, rx_data}, 16'h0053);
      pulse_clears(1'b1, 1'b0, 1'b0);
      send_frame(8'h63, 1'b1, 1'b1);
      chk("R7 mismatch ri", {15'd0, ri}, 16'd0);
      chk("R7 mismatch data", {8'd0, rx_data}, 16'h0053);
   endtask

   task automatic t_broadcast;
      sm2 = 1'b1; node_addr = 8'h5A; addr_mask = 8'hFF;
      send_frame(8'hFF, 1'b1, 1'b1);
      chk("R6 all ones ri", {15'd0, ri}, 16'd1);
      chk("R6 all ones data", {8'd0, rx_data}, 16'h00FF);
      pulse_clears(1'b1, 1'b0, 1'b0);
      node_addr = 8'h30; addr_mask = 8'h0F;
      send_frame(8'hBF, 1'b1, 1'b1);
      chk("R6 partial bcast ri", {15'd0, ri}, 16'd1);
      chk("R6 partial bcast data", {8'd0, rx_data}, 16'h00BF);
      pulse_clears(1'b1, 1'b0, 1'b0);
      sm2 = 1'b0;
   endtask

   task automatic t_tx;
      tx_frame(8'h96, 1'b1, 1'b0, "R8 tx frame");
      wait_clk(200);
      chk("R9 ti holds", {15'd0, ti}, 16'd1);
      pulse_clears(1'b0, 1'b1, 1'b0);
      chk("R9 ti cleared", {15'd0, ti}, 16'd0);
   endtask

   task automatic t_busy_ignore;
      tx_frame(8'h0F, 1'b0, 1'b1, "R10 load ignored while busy");
      wait_clk(3 * BITCLK);
      chk("R10 no second frame", {15'd0, tx_busy}, 16'd0);
      pulse_clears(1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_duplex;
      sm2 = 1'b0;
      fork
         tx_frame(8'hC3, 1'b0, 1'b0, "R11 tx during rx");
         send_frame(8'h81, 1'b1, 1'b1);
      join
      chk("R11 rx during tx data", {8'd0, rx_data}, 16'h0081);
      chk("R11 rx during tx ri", {15'd0, ri}, 16'd1);
      pulse_clears(1'b1, 1'b1, 1'b0);
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      wait_clk(5);
      t_reset();
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_basic_rx();
      t_glitch();
      t_framing();
      t_filter();
      t_broadcast();
      t_tx();
      t_busy_ignore();
      t_duplex();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule